// File: doc/BRIEF.md
# Interrupt Controller Command-Word Sequencer

This block is the programming front end of an eight-line interrupt controller. Software writes single bytes at two offsets. A write at offset 0 is one of three things: the start of an initialization sequence, an end-of-interrupt/priority command, or a read-source/special-mask command. A write at offset 1 is a plain mask update, or it is the next word of an initialization sequence that is in progress. The block holds the configuration that the sequence produces: trigger mode, single or cascade operation, vector base, cascade mask or slave ID, and the auto end-of-interrupt flag. It also holds the mask register.

End-of-interrupt commands become a one-cycle strobe and a line number. The request/in-service logic that consumes them lies outside this block. That logic also supplies the request and in-service vectors, which the block returns on byte reads. Rotation, special-mask and buffer-mode codes are accepted and cause no action.

The sequencer is a four-state machine:
- `STEP_IDLE`: an offset-1 write updates the mask.
- `STEP_BASE`: waits for the vector-base word.
- `STEP_CASC`: waits for the cascade word.
- `STEP_MODE`: waits for the mode word.

Transitions:
- Start: any state goes to `STEP_BASE` on a start write.
- `STEP_BASE` goes to `STEP_CASC` in cascade mode, or to `STEP_IDLE` in single mode.
- `STEP_CASC` goes to `STEP_MODE` when a mode word was announced, otherwise to `STEP_IDLE`.
- `STEP_MODE` returns to `STEP_IDLE`.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset, mask_reg, vec_base, casc_bits, edge_mode, cascade_mode, auto_eoi and eoi_valid are all 0, and offset-0 reads return req_vec.
- R2: A write at offset 0 with bit 4 set starts initialization. The cycle after it:
  - mask_reg is 0.
  - edge_mode equals bit 3.
  - cascade_mode equals the inverse of bit 1.
  - A mode word is expected if bit 0 is 1.
  - If bit 0 is 0, auto_eoi is forced to 0.
- R3: The first offset-1 write after a start stores vec_base as the byte with bits 2:0 cleared. In single mode it also clears casc_bits and ends the sequence.
- R4: In cascade mode the next offset-1 write is the cascade word:
  - With is_master=1, casc_bits takes the whole byte.
  - With is_master=0, casc_bits takes bits 2:0, zero-extended.
  - The sequence then ends, unless a mode word was announced.
- R5: The mode word sets auto_eoi from bit 1 and ends the sequence.
- R6: An offset-1 write outside a sequence loads mask_reg with the byte. mask_reg changes on no cycle without a write.
- R7: An offset-0 write with bits 4:3=00 and bits 7:5=001 makes eoi_valid high for exactly the next cycle. eoi_line then holds the index of the highest set bit of isr_vec. If isr_vec is 0, no strobe is produced.
- R8: An offset-0 write with bits 4:3=00 and bits 7:5=011 produces the strobe on the next cycle, with eoi_line equal to bits 2:0.
- R9: In the bits 4:3=00 group, the codes 000, 010, 100, 101, 110 and 111 in bits 7:5 produce no strobe and change no register.
- R10: An offset-0 write with bits 4:3=01 and bit 1 set selects the offset-0 read source: bit 0=1 selects req_vec and bit 0=0 selects isr_vec. With bit 1 clear, the source is unchanged. Bits 7:6 are ignored.
- R11: rdata follows addr combinationally: offset 0 gives the selected source, offset 1 gives mask_reg.
- R12: Offset-1 writes during an initialization sequence leave mask_reg unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| addr | input | 1 | Register offset (0 or 1) |
| wdata | input | 8 | Write byte |
| is_master | input | 1 | 1: controller is a master; 0: it is a slave |
| req_vec | input | 8 | Request vector from the pending logic |
| isr_vec | input | 8 | In-service vector from the pending logic |
| rdata | output | 8 | Read byte for the current offset |
| mask_reg | output | 8 | Interrupt mask |
| edge_mode | output | 1 | 1: edge-triggered inputs |
| cascade_mode | output | 1 | 1: cascaded controllers |
| vec_base | output | 8 | Vector base, low three bits zero |
| casc_bits | output | 8 | Slave-line mask (master) or slave ID (slave) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| eoi_valid | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_line | output | 3 | Line the strobe refers to |

## Verification
The assertions assume three things about the inputs:
- wr_en is a clean one-cycle strobe per byte.
- addr and wdata are stable while it is high.
- isr_vec does not change in the cycle a non-specific end-of-interrupt byte is written, because the strobe reports that cycle's highest in-service line.

The bench drives each byte away from the clock edge and holds isr_vec steady around every end-of-interrupt write. It changes is_master only between sequences, never inside one.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LINES   = 8;
    localparam int LINE_W  = $clog2(LINES);
    localparam int BYTE_W  = 8;

    // bit positions the command decode depends on
    localparam int B_START = 4;
    localparam int B_GRP   = 3;

    typedef enum logic [1:0] {
        STEP_IDLE,
        STEP_BASE,
        STEP_CASC,
        STEP_MODE
    } step_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_START,
        CMD_EOI_GRP,
        CMD_SEL_GRP,
        CMD_DATA
    } cmd_t;

    localparam logic [2:0] EOI_NONSPEC = 3'b001;
    localparam logic [2:0] EOI_SPEC    = 3'b011;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_pkg::*;
(
    input  logic              wr_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output cmd_t              cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (wr_en) begin
            if (addr) begin
                cmd = CMD_DATA;
            end else if (wdata[B_START]) begin
                cmd = CMD_START;
            end else if (wdata[B_GRP]) begin
                cmd = CMD_SEL_GRP;
            end else begin
                cmd = CMD_EOI_GRP;
            end
        end
    end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              is_master,
    output step_t             step,
    output logic [BYTE_W-1:0] mask_reg,
    output logic              edge_mode,
    output logic              cascade_mode,
    output logic [BYTE_W-1:0] vec_base,
    output logic [BYTE_W-1:0] casc_bits,
    output logic              auto_eoi
);
    step_t step_q, step_d;
    logic  want_mode;

    assign step = step_q;

    // next-state decision
    always_comb begin
        step_d = step_q;
        if (cmd == CMD_START) begin
            step_d = STEP_BASE;
        end else if (cmd == CMD_DATA) begin
            unique case (step_q)
                STEP_IDLE: step_d = STEP_IDLE;
                STEP_BASE: step_d = cascade_mode ? STEP_CASC : STEP_IDLE;
                STEP_CASC: step_d = want_mode ? STEP_MODE : STEP_IDLE;
                STEP_MODE: step_d = STEP_IDLE;
                default:   step_d = STEP_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= STEP_IDLE;
        else        step_q <= step_d;
    end

    // configuration outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_reg     <= '0;
            edge_mode    <= 1'b0;
            cascade_mode <= 1'b0;
            want_mode    <= 1'b0;
            vec_base     <= '0;
            casc_bits    <= '0;
            auto_eoi     <= 1'b0;
        end else if (cmd == CMD_START) begin
            mask_reg     <= '0;
            edge_mode    <= wdata[3];
            cascade_mode <= ~wdata[1];
            want_mode    <= wdata[0];
            if (!wdata[0]) auto_eoi <= 1'b0;
        end else if (cmd == CMD_DATA) begin
            unique case (step_q)
                STEP_IDLE: mask_reg <= wdata;
                STEP_BASE: begin
                    vec_base <= {wdata[BYTE_W-1:LINE_W], {LINE_W{1'b0}}};
                    if (!cascade_mode) casc_bits <= '0;
                end
                STEP_CASC: begin
                    if (is_master) casc_bits <= wdata;
                    else           casc_bits <= {{(BYTE_W-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
                end
                STEP_MODE: auto_eoi <= wdata[1];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [LINES-1:0]  isr_vec,
    output logic              eoi_valid,
    output logic [LINE_W-1:0] eoi_line
);
    logic [LINE_W-1:0] top_line;
    logic              any_isr;

    always_comb begin
        top_line = '0;
        for (int i = 0; i < LINES; i++) begin
            if (isr_vec[i]) top_line = LINE_W'(i);
        end
    end

    assign any_isr = |isr_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_valid <= 1'b0;
            eoi_line  <= '0;
        end else begin
            eoi_valid <= 1'b0;
            if (cmd == CMD_EOI_GRP) begin
                if (wdata[7:5] == EOI_NONSPEC && any_isr) begin
                    eoi_valid <= 1'b1;
                    eoi_line  <= top_line;
                end else if (wdata[7:5] == EOI_SPEC) begin
                    eoi_valid <= 1'b1;
                    eoi_line  <= wdata[LINE_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/pic_rd_sel.sv
module pic_rd_sel
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              addr,
    input  logic [LINES-1:0]  req_vec,
    input  logic [LINES-1:0]  isr_vec,
    input  logic [BYTE_W-1:0] mask_reg,
    output logic [BYTE_W-1:0] rdata
);
    logic sel_req;

    always_ff @(posedge clk) begin
        if (!rst_n)                              sel_req <= 1'b1;
        else if (cmd == CMD_SEL_GRP && wdata[1]) sel_req <= wdata[0];
    end

    always_comb begin
        if (addr)         rdata = mask_reg;
        else if (sel_req) rdata = BYTE_W'(req_vec);
        else              rdata = BYTE_W'(isr_vec);
    end
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [7:0]        wdata,
    input  logic              is_master,
    input  logic [7:0]        req_vec,
    input  logic [7:0]        isr_vec,
    output logic [7:0]        rdata,
    output logic [7:0]        mask_reg,
    output logic              edge_mode,
    output logic              cascade_mode,
    output logic [7:0]        vec_base,
    output logic [7:0]        casc_bits,
    output logic              auto_eoi,
    output logic              eoi_valid,
    output logic [2:0]        eoi_line
);
    cmd_t  cmd;
    step_t step;

    pic_cmd_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    pic_init_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .wdata        (wdata),
        .is_master    (is_master),
        .step         (step),
        .mask_reg     (mask_reg),
        .edge_mode    (edge_mode),
        .cascade_mode (cascade_mode),
        .vec_base     (vec_base),
        .casc_bits    (casc_bits),
        .auto_eoi     (auto_eoi)
    );

    pic_eoi_gen u_eoi (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .wdata     (wdata),
        .isr_vec   (isr_vec),
        .eoi_valid (eoi_valid),
        .eoi_line  (eoi_line)
    );

    pic_rd_sel u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .wdata    (wdata),
        .addr     (addr),
        .req_vec  (req_vec),
        .isr_vec  (isr_vec),
        .mask_reg (mask_reg),
        .rdata    (rdata)
    );
endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk
    import pic_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] mask_reg,
    input logic       auto_eoi,
    input logic       eoi_valid,
    input logic [2:0] eoi_line,
    input step_t      step
);
    // R2: a start write empties the mask
    assert_start_clears_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (mask_reg == 8'h00));

    // R2: start without mode word forces auto end-of-interrupt off
    assert_no_mode_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4] && !wdata[0]) |=> !auto_eoi);

    // R6: the mask only moves on a write
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_reg));

    // R12: data words inside a sequence leave the mask alone
    assert_seq_mask_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && step != STEP_IDLE) |=> $stable(mask_reg));

    // R8: a specific end-of-interrupt strobes the written line
    assert_spec_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'b011)
        |=> (eoi_valid && eoi_line == $past(wdata[2:0])));

    // R9: a strobe has an end-of-interrupt write behind it
    assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(wr_en && !addr && wdata[4:3] == 2'b00 &&
                            (wdata[7:5] == 3'b001 || wdata[7:5] == 3'b011)));
endmodule

bind pic_cmd_seq pic_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .mask_reg  (mask_reg),
    .auto_eoi  (auto_eoi),
    .eoi_valid (eoi_valid),
    .eoi_line  (eoi_line),
    .step      (step)
);

// File: tb/pic_cmd_seq_tb.sv
module pic_cmd_seq_tb;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       is_master = 1'b1;
    logic [7:0] req_vec = 8'hA5;
    logic [7:0] isr_vec = 8'h3C;
    logic [7:0] rdata, mask_reg, vec_base, casc_bits;
    logic       edge_mode, cascade_mode, auto_eoi, eoi_valid;
    logic [2:0] eoi_line;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef enum int {S_RDATA, S_MASK, S_EDGE, S_CASC, S_BASE, S_CBITS, S_AUTO, S_EOIV, S_EOIL} sig_t;
    typedef struct {
        sig_t       sig;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    pic_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .is_master(is_master), .req_vec(req_vec), .isr_vec(isr_vec),
        .rdata(rdata), .mask_reg(mask_reg), .edge_mode(edge_mode),
        .cascade_mode(cascade_mode), .vec_base(vec_base), .casc_bits(casc_bits),
        .auto_eoi(auto_eoi), .eoi_valid(eoi_valid), .eoi_line(eoi_line)
    );

    function automatic logic [7:0] observe(sig_t s);
        case (s)
            S_RDATA: return rdata;
            S_MASK:  return mask_reg;
            S_EDGE:  return {7'd0, edge_mode};
            S_CASC:  return {7'd0, cascade_mode};
            S_BASE:  return vec_base;
            S_CBITS: return casc_bits;
            S_AUTO:  return {7'd0, auto_eoi};
            S_EOIV:  return {7'd0, eoi_valid};
            default: return {5'd0, eoi_line};
        endcase
    endfunction

    // monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                logic [7:0] got;
                e = sb.pop_front();
                got = observe(e.sig);
                total++;
                if (got !== e.val) begin
                    bad++;
                    $display("FAIL %s: %s got %02h expected %02h", e.tag, e.sig.name(), got, e.val);
                end
            end
        end
    end

    task automatic expect_val(sig_t s, logic [7:0] v, string tag);
        exp_t e;
        e.sig = s; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic write_byte(logic a, logic [7:0] d);
        @(negedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic read_at(logic a, logic [7:0] v, string tag);
        @(negedge clk); #1;
        addr = a;
        expect_val(S_RDATA, v, tag);
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_val(S_MASK, 8'h00, "R1");
        expect_val(S_BASE, 8'h00, "R1");
        expect_val(S_CBITS, 8'h00, "R1");
        expect_val(S_EDGE, 8'h00, "R1");
        expect_val(S_CASC, 8'h00, "R1");
        expect_val(S_AUTO, 8'h00, "R1");
        expect_val(S_EOIV, 8'h00, "R1");
        read_at(1'b0, 8'hA5, "R1 R11 request source after reset");

        // R6 idle mask write, R11 offset-1 read
        write_byte(1'b1, 8'h5A);
        expect_val(S_MASK, 8'h5A, "R6");
        read_at(1'b1, 8'h5A, "R11");

        // R2/R3 single mode, no mode word
        write_byte(1'b0, 8'h1A);
        expect_val(S_MASK, 8'h00, "R2 mask cleared");
        expect_val(S_EDGE, 8'h01, "R2 edge");
        expect_val(S_CASC, 8'h00, "R2 single");
        expect_val(S_AUTO, 8'h00, "R2 auto off");
        write_byte(1'b1, 8'h47);
        expect_val(S_BASE, 8'h40, "R3 base");
        expect_val(S_CBITS, 8'h00, "R3 cascade bits cleared");
        expect_val(S_MASK, 8'h00, "R12 base word not a mask");
        write_byte(1'b1, 8'h33);
        expect_val(S_MASK, 8'h33, "R3 sequence ended");

        // R4/R5 master cascade with mode word
        is_master = 1'b1;
        write_byte(1'b0, 8'h11);
        expect_val(S_EDGE, 8'h00, "R2 level");
        expect_val(S_CASC, 8'h01, "R2 cascade");
        expect_val(S_MASK, 8'h00, "R2 mask cleared");
        write_byte(1'b1, 8'h2F);
        expect_val(S_BASE, 8'h28, "R3 base");
        expect_val(S_MASK, 8'h00, "R12");
        write_byte(1'b1, 8'h84);
        expect_val(S_CBITS, 8'h84, "R4 master mask");
        expect_val(S_MASK, 8'h00, "R12");
        write_byte(1'b1, 8'h03);
        expect_val(S_AUTO, 8'h01, "R5 auto on");
        expect_val(S_MASK, 8'h00, "R12");
        write_byte(1'b1, 8'h0F);
        expect_val(S_MASK, 8'h0F, "R5 sequence ended");

        // R2/R4 slave cascade without mode word
        is_master = 1'b0;
        write_byte(1'b0, 8'h10);
        expect_val(S_AUTO, 8'h00, "R2 auto forced off");
        write_byte(1'b1, 8'h60);
        expect_val(S_BASE, 8'h60, "R3 base");
        write_byte(1'b1, 8'hFE);
        expect_val(S_CBITS, 8'h06, "R4 slave id");
        write_byte(1'b1, 8'h77);
        expect_val(S_MASK, 8'h77, "R4 sequence ended");

        // R7 non-specific end-of-interrupt
        isr_vec = 8'h2C;
        write_byte(1'b0, 8'h20);
        expect_val(S_EOIV, 8'h01, "R7 strobe");
        expect_val(S_EOIL, 8'h05, "R7 highest line");
        idle_cycle();
        expect_val(S_EOIV, 8'h00, "R7 single cycle");
        isr_vec = 8'h00;
        write_byte(1'b0, 8'h20);
        expect_val(S_EOIV, 8'h00, "R7 nothing in service");

        // R8 specific end-of-interrupt
        write_byte(1'b0, 8'h63);
        expect_val(S_EOIV, 8'h01, "R8 strobe");
        expect_val(S_EOIL, 8'h03, "R8 line");

        // R9 the other codes do nothing
        foreach (sb[i]) ;
        begin
            logic [7:0] codes [6] = '{8'h01, 8'h46, 8'h85, 8'hA2, 8'hC7, 8'hE4};
            for (int k = 0; k < 6; k++) begin
                write_byte(1'b0, codes[k]);
                expect_val(S_EOIV, 8'h00, "R9 no strobe");
                expect_val(S_MASK, 8'h77, "R9 mask unchanged");
                expect_val(S_BASE, 8'h60, "R9 base unchanged");
            end
        end

        // R10 read source select
        isr_vec = 8'h3C;
        write_byte(1'b0, 8'h0A);
        read_at(1'b0, 8'h3C, "R10 in-service selected");
        write_byte(1'b0, 8'h08);
        read_at(1'b0, 8'h3C, "R10 bit1 clear keeps source");
        write_byte(1'b0, 8'hCB);
        read_at(1'b0, 8'hA5, "R10 request selected, bits 7:6 ignored");
        read_at(1'b1, 8'h77, "R11 mask read");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule